// File: doc/BRIEF.md
# Power-On Reset Sequencer with Delay Stretch

This block produces the single internal reset for a small controller core. Two sources can request it. The first is an external active-low reset pin. It is synchronized and must stay low for a minimum run of clock cycles before it is accepted. The second is a supply-detect comparator output. When the on-chip power-on option is enabled, the rising edge of this output starts a 12-bit down-counter. The counter is preset to all ones, and reset is held until the counter underflows. That gives a 4096-cycle stretch after the supply becomes good.

Once the stretch has ended, the sequencer stays quiet for as long as supply-ok stays high. A drop of supply-ok clears the sequencer state and re-arms the stretch. Both sources drive the same internal reset. That reset is asserted asynchronously, as soon as a request exists, and released synchronously through a short synchronizer. An accepted pin reset also raises a wake request when the core is halted. While reset is asserted, a watchdog-window configuration output is forced to its maximum setting.

All interfaces are plain control levels. There is no data stream, so no valid/ready handshake and no back-pressure apply.

Top module: `reset_sequencer`

## Requirements
- R1: With por_en high, rst_n is low whenever supply_ok is low. It goes low at once when supply_ok falls, without waiting for a clock edge.
- R2: After supply_ok rises (with por_en high), rst_n stays low through the first 4100 rising clock edges and is high after the 4101st. This is 2 synchronizer edges, 1 edge that loads the timer with 0xFFF, 4096 counting edges ending in underflow, and 2 release edges.
- R3: Once the stretch has ended, rst_n does not fall again while supply_ok stays high and the pin stays high.
- R4: A fall and a later rise of supply_ok re-arms the sequencer, and the full R2 stretch is repeated.
- R5: With por_en low, changes of supply_ok produce no low on rst_n.
- R6: A low on ext_rst_n is accepted once it has been seen for INSTR_CYC consecutive synchronized cycles. Holding the pin low makes rst_n fall right after rising edge INSTR_CYC+2, counted from the first edge that sees the pin low.
- R7: A pin low lasting fewer than INSTR_CYC clock cycles, including a glitch between two edges, never makes rst_n low.
- R8: After the pin returns high following an accepted reset, rst_n is still low after 4 rising edges and is high after the 5th.
- R9: wake_req is high exactly while a pin reset is accepted and halted is high. It is low when halted is low and once the pin reset has ended.
- R10: wdog_win equals all ones while rst_n is low, and equals wdog_cfg while rst_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| supply_ok | input | 1 | Supply-detect comparator output, high when the supply is above threshold; low also clears the sequencer state |
| por_en | input | 1 | Enables the power-on reset stretch |
| halted | input | 1 | Core is in its halt low-power state |
| wdog_cfg | input | WIN_W | Watchdog window setting used outside reset |
| rst_n | output | 1 | Internal reset, active low |
| wake_req | output | 1 | Request to leave halt, raised by an accepted pin reset |
| wdog_win | output | WIN_W | Watchdog window in effect, all ones during reset |

## Verification
The hardest state to reach is the exact end of the 4096-cycle stretch, together with the re-arm that follows a supply dip. The bench raises supply-ok on a known falling edge and counts edges until the cycle just before release and the cycle of release. It then lowers and raises supply-ok again and repeats the same count. The pin filter is driven from a table of pulse lengths that straddle the acceptance threshold, with the bench instance set to a three-cycle minimum. A sub-cycle glitch placed between two rising edges shows that a pulse no edge ever samples is rejected.

// File: rtl/rstseq_pkg.sv
`timescale 1ns/1ps
package rstseq_pkg;
  typedef enum logic [1:0] {
    POR_ARMED = 2'd0,
    POR_COUNT = 2'd1,
    POR_DONE  = 2'd2
  } por_state_e;
endpackage

// File: rtl/rstseq_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer with asynchronous clear to a chosen value.
module rstseq_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic clr_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic ff;
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) ff <= RST_VAL;
        else        ff <= d;
      end
      assign q = ff;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) sh <= {STAGES{RST_VAL}};
        else        sh <= {sh[STAGES-2:0], d};
      end
      assign q = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/rstseq_pin_filter.sv
`timescale 1ns/1ps
// Synchronizes the external reset pin and accepts a low only after a minimum run.
module rstseq_pin_filter #(
  parameter int unsigned MIN_LOW     = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  input  logic pin_n,
  output logic accepted
);
  localparam int unsigned    CW   = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0]  CMAX = CW'(MIN_LOW);

  logic          pin_s;
  logic [CW-1:0] low_cnt;

  rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk   (clk),
    .clr_n (clr_n),
    .d     (pin_n),
    .q     (pin_s)
  );

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)               low_cnt <= '0;
    else if (pin_s)           low_cnt <= '0;
    else if (low_cnt != CMAX) low_cnt <= low_cnt + 1'b1;
  end

  assign accepted = (low_cnt == CMAX);

  // R7: acceptance can only begin after a sampled low
  a_r7_needs_low: assert property (@(posedge clk) disable iff (!clr_n)
    $rose(accepted) |-> !$past(pin_s));
  // R6: a held low keeps the request
  a_r6_held_low: assert property (@(posedge clk) disable iff (!clr_n)
    (accepted && !pin_s) |=> accepted);
endmodule

// File: rtl/rstseq_por_timer.sv
`timescale 1ns/1ps
// Power-on stretch: preset the down-counter to all ones, hold until it underflows.
module rstseq_por_timer #(
  parameter int unsigned TMR_W       = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic supply_ok,
  output logic hold
);
  import rstseq_pkg::*;

  localparam logic [TMR_W-1:0] PRESET = '1;

  logic             sup_s;
  por_state_e       st;
  logic [TMR_W-1:0] cnt;

  rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sup_sync (
    .clk   (clk),
    .clr_n (supply_ok),
    .d     (1'b1),
    .q     (sup_s)
  );

  always_ff @(posedge clk or negedge supply_ok) begin
    if (!supply_ok) begin
      st  <= POR_ARMED;
      cnt <= '0;
    end else begin
      unique case (st)
        POR_ARMED: if (sup_s) begin
          st  <= POR_COUNT;
          cnt <= PRESET;
        end
        POR_COUNT: begin
          if (cnt == '0) st <= POR_DONE;
          else           cnt <= cnt - 1'b1;
        end
        POR_DONE: st <= POR_DONE;
        default:  st <= POR_ARMED;
      endcase
    end
  end

  assign hold = (st != POR_DONE);

  // R2: the stretch starts from the full preset
  a_r2_preset: assert property (@(posedge clk) disable iff (!supply_ok)
    $rose(st == POR_COUNT) |-> (cnt == PRESET));
  // R2: one step per cycle while counting
  a_r2_step: assert property (@(posedge clk) disable iff (!supply_ok)
    (st == POR_COUNT && cnt != '0) |=> (st == POR_COUNT && cnt == $past(cnt) - 1'b1));
  // R3: no re-trigger while supply stays good
  a_r3_sticky: assert property (@(posedge clk) disable iff (!supply_ok)
    (st == POR_DONE) |=> (st == POR_DONE));
endmodule

// File: rtl/reset_sequencer.sv
`timescale 1ns/1ps
module reset_sequencer #(
  parameter int unsigned TMR_W       = 12,
  parameter int unsigned INSTR_CYC   = 1,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WIN_W       = 4
) (
  input  logic             clk,
  input  logic             ext_rst_n,
  input  logic             supply_ok,
  input  logic             por_en,
  input  logic             halted,
  input  logic [WIN_W-1:0] wdog_cfg,
  output logic             rst_n,
  output logic             wake_req,
  output logic [WIN_W-1:0] wdog_win
);
  logic pin_acc;
  logic por_hold;
  logic req;
  logic rel_clr_n;

  rstseq_pin_filter #(.MIN_LOW(INSTR_CYC), .SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk      (clk),
    .clr_n    (supply_ok),
    .pin_n    (ext_rst_n),
    .accepted (pin_acc)
  );

  rstseq_por_timer #(.TMR_W(TMR_W), .SYNC_STAGES(SYNC_STAGES)) u_por (
    .clk       (clk),
    .supply_ok (supply_ok),
    .hold      (por_hold)
  );

  // Either source asserts reset at once; release waits for the synchronizer.
  assign req       = pin_acc | (por_en & por_hold);
  assign rel_clr_n = ~req;

  rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_release (
    .clk   (clk),
    .clr_n (rel_clr_n),
    .d     (1'b1),
    .q     (rst_n)
  );

  assign wake_req = halted & pin_acc;
  assign wdog_win = rst_n ? wdog_cfg : {WIN_W{1'b1}};

  // R1: an armed or counting power-on stretch always holds reset
  a_r1_por_holds: assert property (@(posedge clk) disable iff (!supply_ok)
    (por_en && por_hold) |-> !rst_n);
  // R8: release only after the request has been gone for a full cycle
  a_r8_sync_release: assert property (@(posedge clk) disable iff (!supply_ok)
    $rose(rst_n) |-> (!req && $past(!req)));
  // R9: a wake request only comes with reset held
  a_r9_wake_in_reset: assert property (@(posedge clk) disable iff (!supply_ok)
    wake_req |-> !rst_n);
endmodule

// File: tb/reset_sequencer_tb.sv
`timescale 1ns/1ps
module reset_sequencer_tb;
  localparam int unsigned INSTR = 3;
  localparam int unsigned WW    = 4;

  logic          clk = 1'b0;
  logic          ext_rst_n = 1'b1;
  logic          supply_ok = 1'b0;
  logic          por_en = 1'b1;
  logic          halted = 1'b0;
  logic [WW-1:0] wdog_cfg = 4'h5;
  logic          rst_n;
  logic          wake_req;
  logic [WW-1:0] wdog_win;

  int n_chk = 0;
  int n_err = 0;
  logic lo_seen = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  reset_sequencer #(.INSTR_CYC(INSTR), .WIN_W(WW)) u_dut (
    .clk(clk), .ext_rst_n(ext_rst_n), .supply_ok(supply_ok), .por_en(por_en),
    .halted(halted), .wdog_cfg(wdog_cfg), .rst_n(rst_n), .wake_req(wake_req),
    .wdog_win(wdog_win)
  );

  always @(rst_n) if (rst_n === 1'b0) lo_seen = 1'b1;

  // Pin pulse table: {length[4:0], halted, expect_accept}
  localparam int NV = 6;
  localparam logic [6:0] VEC [NV] = '{
    {5'd1, 1'b0, 1'b0},
    {5'd2, 1'b1, 1'b0},
    {5'd3, 1'b0, 1'b1},
    {5'd3, 1'b1, 1'b1},
    {5'd4, 1'b1, 1'b1},
    {5'd7, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(60000 * 20);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=1 expected=0");
      report();
    end
  end

  initial begin
    // Reset state: supply low with power-on enabled
    #1;
    chk("R1 reset at time zero", rst_n, 0);
    chk("R10 window max in reset", wdog_win, 4'hF);

    // R2: stretch length
    @(negedge clk); supply_ok = 1'b1;
    step(4100);
    chk("R2 still held at edge 4100", rst_n, 0);
    step(1);
    chk("R2 released at edge 4101", rst_n, 1);
    chk("R10 window follows cfg", wdog_win, 4'h5);

    // R3: quiet afterwards
    lo_seen = 1'b0;
    step(300);
    chk("R3 no retrigger", lo_seen, 0);

    // R1 / R4: dip and re-arm
    supply_ok = 1'b0;
    #1;
    chk("R1 immediate assert on supply drop", rst_n, 0);
    step(3);
    supply_ok = 1'b1;
    step(4100);
    chk("R4 re-armed, held at edge 4100", rst_n, 0);
    step(1);
    chk("R4 re-armed, released at edge 4101", rst_n, 1);

    // R5: power-on disabled
    por_en = 1'b0;
    lo_seen = 1'b0;
    supply_ok = 1'b0;
    #1;
    chk("R5 no reset on drop when disabled", rst_n, 1);
    step(3);
    supply_ok = 1'b1;
    step(20);
    chk("R5 no reset on rise when disabled", lo_seen, 0);

    // R6 / R7 / R9 / R10: pin pulse table
    for (int i = 0; i < NV; i++) begin
      logic [4:0] len;
      logic       h;
      logic       acc;
      len = VEC[i][6:2];
      h   = VEC[i][1];
      acc = VEC[i][0];
      lo_seen = 1'b0;
      halted = h;
      ext_rst_n = 1'b0;
      step(int'(len));
      ext_rst_n = 1'b1;
      step(2);
      if (acc) begin
        chk($sformatf("R6 pulse len %0d accepted", len), rst_n, 0);
        chk($sformatf("R9 wake for len %0d halted %0d", len, h), wake_req, h);
        chk($sformatf("R10 window max for len %0d", len), wdog_win, 4'hF);
      end else begin
        chk($sformatf("R7 pulse len %0d rejected", len), lo_seen, 0);
        chk($sformatf("R9 no wake for len %0d", len), wake_req, 0);
      end
      step(8);
      chk($sformatf("R8 recovered after len %0d", len), rst_n, 1);
      chk($sformatf("R9 wake cleared after len %0d", len), wake_req, 0);
      halted = 1'b0;
    end

    // R6 exact assert edge and R8 exact release edge
    ext_rst_n = 1'b0;
    step(INSTR + 1);
    chk("R6 not yet accepted one edge early", rst_n, 1);
    step(1);
    chk("R6 accepted at edge INSTR+2", rst_n, 0);
    step(1);
    ext_rst_n = 1'b1;
    step(4);
    chk("R8 still held at edge 4", rst_n, 0);
    step(1);
    chk("R8 released at edge 5", rst_n, 1);

    // R7: glitch between two rising edges
    lo_seen = 1'b0;
    #2 ext_rst_n = 1'b0;
    #5 ext_rst_n = 1'b1;
    step(6);
    chk("R7 sub-cycle glitch ignored", lo_seen, 0);

    done = 1'b1;
    report();
  end
endmodule